// File: doc/BRIEF.md
# XON/XOFF Software Flow Controller

This block adds in-band software flow control to a UART datapath. On the receive side it watches every incoming character and compares it with four programmable flow characters: two "resume" characters (XON 1 and XON 2) and two "stop" characters (XOFF 1 and XOFF 2). A matched stop character pauses the local transmitter once the frame it is sending has finished. A matched resume character releases it. Matched flow characters are taken out of the stream before it reaches the receive FIFO.

On the transmit side the block watches the fill level of the receive FIFO. When the level climbs to the programmed halt level, it asks the transmitter to send a stop character once. When the level later drops to the resume level or below, it asks for a resume character once. Both levels are 4-bit values counted in units of eight FIFO words. The injection request is separate from the pause output. The transmitter serves it ahead of normal FIFO data, even while it is paused. A sticky status byte records which flow characters were recognised, and reading it clears it.

Two independent 2-bit fields choose the characters used in each direction. One field chooses which characters are matched on receive, and the other chooses which are generated on transmit. In the paired setting, a pair of characters on consecutive received characters forms one event.

Top module: `swfc_flow_ctrl`

## Requirements
- R1: After reset, `tx_pause`, `inj_req` and `fwd_valid` are low and `stat_byte` is 0.
- R2: While control bit 3 (master enable, `ctl_bits[3]`) is 0, no character is matched. Every character is forwarded, no status bit sets, `tx_pause` stays low and `inj_req` stays low.
- R3: Receive matching is selected by `ctl_bits[5:4]`:
  - 00 matches nothing.
  - 01 matches XON 2 as resume and XOFF 2 as stop.
  - 10 matches XON 1 as resume and XOFF 1 as stop.
- R4: With `ctl_bits[5:4]` = 11, a resume event needs XON 1 followed by XON 2 on consecutive received characters, and a stop event needs XOFF 1 followed by XOFF 2. Only the second character is withheld. Any other character between the two breaks the pair. Idle cycles between the two do not.
- R5: A stop event sets `tx_pause` no earlier than two clock edges after the character is taken. While `tx_frame_busy` is high, setting it waits until `tx_frame_busy` is low at an edge.
- R6: A resume event clears `tx_pause` at the same edge that takes the character.
- R7: A character that is not a matched flow character appears on `fwd_valid`/`fwd_data` one cycle after it is taken, unchanged. A matched character is not forwarded.
- R8: With generation enabled, the stop sequence is requested once when `rx_level` >= `halt_units`*8. It is not requested again until a resume sequence has been sent.
- R9: After a stop sequence, the resume sequence is requested once when `rx_level` <= `resume_units`*8.
- R10: Generation is selected by `ctl_bits[7:6]`:
  - 01 sends XOFF 2 or XON 2.
  - 10 sends XOFF 1 or XON 1.
  - 11 sends XOFF 1 then XOFF 2, or XON 1 then XON 2.

  `inj_req` and `inj_char` hold steady until `inj_ack`, and each acknowledge advances to the next character.
- R11: `stat_byte` bits 0 to 3 are sticky flags for XON 1, XON 2, XOFF 1 and XOFF 2. A paired event sets both of its bits. `stat_rd` clears them at the next edge, and a flag set in that same cycle survives the clear. Bits 7:4 read 0.
- R12: Turning off receive matching clears `tx_pause` at the next edge. Turning off generation drops `inj_req` at the next edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ctl_bits | input | 5 | Control byte bits 7:3: [3] master enable, [5:4] receive match mode, [7:6] transmit generate mode |
| chr_on_a | input | CHAR_W | XON 1 character |
| chr_on_b | input | CHAR_W | XON 2 character |
| chr_off_a | input | CHAR_W | XOFF 1 character |
| chr_off_b | input | CHAR_W | XOFF 2 character |
| halt_units | input | THR_W | Halt level in units of 8 words |
| resume_units | input | THR_W | Resume level in units of 8 words |
| rx_valid | input | 1 | Received character strobe |
| rx_data | input | CHAR_W | Received character |
| fwd_valid | output | 1 | Character forwarded to the receive FIFO |
| fwd_data | output | CHAR_W | Forwarded character |
| rx_level | input | LVL_W | Receive FIFO fill level in words |
| tx_frame_busy | input | 1 | Transmitter is in the middle of a frame |
| tx_pause | output | 1 | Hold the transmitter after its current frame |
| inj_req | output | 1 | Request to send a flow character next |
| inj_char | output | CHAR_W | Flow character to send |
| inj_ack | input | 1 | Transmitter accepted `inj_char` |
| stat_rd | input | 1 | Status read strobe, clears the flags |
| stat_byte | output | 8 | Sticky flow character flags |

## Verification
The assertions check on every cycle that:
- `tx_pause` never rises after an edge at which a frame was in progress.
- A pending injection holds its character until it is acknowledged.
- Forwarded output only follows a taken character.
- Status flags never drop without a read.
- Disabling either direction silences its output at the next edge.

Only the bench scenarios can show the rest:
- Which character values each mode matches or generates.
- The pairing rule, including a broken pair.
- The halt and resume levels in units of eight, with single-shot injection at each crossing.
- The two-character sequences in paired generation.

// File: rtl/swfc_pkg.sv
package swfc_pkg;

   localparam int NUM_CHARS = 4;

   // index of each flow character in the character array and status byte
   localparam int IDX_ON_A  = 0;
   localparam int IDX_ON_B  = 1;
   localparam int IDX_OFF_A = 2;
   localparam int IDX_OFF_B = 3;

   // position of fields inside the control bits (byte bits 7:3)
   localparam int CTL_EN  = 3;
   localparam int CTL_RXL = 4;
   localparam int CTL_TXL = 6;

   typedef enum logic [1:0] {
      FC_NONE = 2'b00,
      FC_SETB = 2'b01,
      FC_SETA = 2'b10,
      FC_PAIR = 2'b11
   } fc_sel_e;

   typedef enum logic [1:0] {
      INJ_IDLE   = 2'b00,
      INJ_FIRST  = 2'b01,
      INJ_SECOND = 2'b10
   } inj_state_e;

endpackage

// File: rtl/swfc_rx_match.sv
module swfc_rx_match
   import swfc_pkg::*;
#(
   parameter int CHAR_W = 8
) (
   input  logic                                clk,
   input  logic                                rst_n,
   input  logic                                enable,
   input  logic [1:0]                          sel,
   input  logic [NUM_CHARS-1:0][CHAR_W-1:0]    chars,
   input  logic                                rx_valid,
   input  logic [CHAR_W-1:0]                   rx_data,
   output logic                                fwd_valid,
   output logic [CHAR_W-1:0]                   fwd_data,
   output logic                                on_evt,
   output logic                                off_evt,
   output logic [NUM_CHARS-1:0]                hit_set
);

   logic [NUM_CHARS-1:0] eq;
   logic                 arm_on;
   logic                 arm_off;
   logic                 on_raw;
   logic                 off_raw;

   // one comparator per programmable character
   for (genvar i = 0; i < NUM_CHARS; i++) begin : g_cmp
      assign eq[i] = (rx_data == chars[i]);
   end

   always_comb begin
      on_raw  = 1'b0;
      off_raw = 1'b0;
      unique case (sel)
         FC_SETB: begin
            on_raw  = eq[IDX_ON_B];
            off_raw = eq[IDX_OFF_B];
         end
         FC_SETA: begin
            on_raw  = eq[IDX_ON_A];
            off_raw = eq[IDX_OFF_A];
         end
         FC_PAIR: begin
            on_raw  = arm_on  & eq[IDX_ON_B];
            off_raw = arm_off & eq[IDX_OFF_B];
         end
         default: ;
      endcase
   end

   assign on_evt  = enable & rx_valid & on_raw;
   assign off_evt = enable & rx_valid & off_raw;

   always_comb begin
      hit_set = '0;
      if (on_evt) begin
         if (sel != 2'(FC_SETB)) hit_set[IDX_ON_A] = 1'b1;
         if (sel != 2'(FC_SETA)) hit_set[IDX_ON_B] = 1'b1;
      end
      if (off_evt) begin
         if (sel != 2'(FC_SETB)) hit_set[IDX_OFF_A] = 1'b1;
         if (sel != 2'(FC_SETA)) hit_set[IDX_OFF_B] = 1'b1;
      end
   end

   // the first half of a pair arms the matcher; any other character disarms
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         arm_on    <= 1'b0;
         arm_off   <= 1'b0;
         fwd_valid <= 1'b0;
         fwd_data  <= '0;
      end else begin
         if (rx_valid) begin
            arm_on  <= eq[IDX_ON_A];
            arm_off <= eq[IDX_OFF_A];
         end
         fwd_valid <= rx_valid & ~(on_evt | off_evt);
         if (rx_valid) fwd_data <= rx_data;
      end
   end

endmodule

// File: rtl/swfc_pause.sv
module swfc_pause #(
   parameter bit WAIT_FRAME = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic enable,
   input  logic on_evt,
   input  logic off_evt,
   input  logic frame_busy,
   output logic pause
);

   logic gate;
   logic pause_req;

   if (WAIT_FRAME) begin : g_frame_wait
      assign gate = ~frame_busy;
   end else begin : g_no_wait
      logic unused_busy;
      assign unused_busy = frame_busy;
      assign gate        = 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pause_req <= 1'b0;
         pause     <= 1'b0;
      end else if (!enable || on_evt) begin
         pause_req <= 1'b0;
         pause     <= 1'b0;
      end else if (off_evt) begin
         pause_req <= 1'b1;
      end else if (pause_req && gate) begin
         pause     <= 1'b1;
      end
   end

endmodule

// File: rtl/swfc_tx_inject.sv
module swfc_tx_inject
   import swfc_pkg::*;
#(
   parameter int CHAR_W     = 8,
   parameter int LVL_W      = 8,
   parameter int THR_W      = 4,
   parameter int UNIT_SHIFT = 3
) (
   input  logic                             clk,
   input  logic                             rst_n,
   input  logic                             enable,
   input  logic [1:0]                       sel,
   input  logic [NUM_CHARS-1:0][CHAR_W-1:0] chars,
   input  logic [LVL_W-1:0]                 level,
   input  logic [THR_W-1:0]                 halt_units,
   input  logic [THR_W-1:0]                 resume_units,
   input  logic                             ack,
   output logic                             req,
   output logic [CHAR_W-1:0]                chr
);

   logic [LVL_W-1:0] halt_th;
   logic [LVL_W-1:0] resume_th;
   inj_state_e       state;
   fc_sel_e          mode_q;
   logic             kind_off;
   logic             sent_off;

   assign halt_th   = LVL_W'(halt_units)   << UNIT_SHIFT;
   assign resume_th = LVL_W'(resume_units) << UNIT_SHIFT;

   assign req = (state != INJ_IDLE);

   always_comb begin
      if (state == INJ_SECOND || mode_q == FC_SETB)
         chr = kind_off ? chars[IDX_OFF_B] : chars[IDX_ON_B];
      else
         chr = kind_off ? chars[IDX_OFF_A] : chars[IDX_ON_A];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state    <= INJ_IDLE;
         mode_q   <= FC_NONE;
         kind_off <= 1'b0;
         sent_off <= 1'b0;
      end else if (!enable) begin
         state    <= INJ_IDLE;
         sent_off <= 1'b0;
      end else begin
         unique case (state)
            INJ_IDLE: begin
               if (!sent_off && level >= halt_th) begin
                  state    <= INJ_FIRST;
                  kind_off <= 1'b1;
                  sent_off <= 1'b1;
                  mode_q   <= fc_sel_e'(sel);
               end else if (sent_off && level <= resume_th) begin
                  state    <= INJ_FIRST;
                  kind_off <= 1'b0;
                  sent_off <= 1'b0;
                  mode_q   <= fc_sel_e'(sel);
               end
            end
            INJ_FIRST: begin
               if (ack) state <= (mode_q == FC_PAIR) ? INJ_SECOND : INJ_IDLE;
            end
            INJ_SECOND: begin
               if (ack) state <= INJ_IDLE;
            end
            default: state <= INJ_IDLE;
         endcase
      end
   end

endmodule

// File: rtl/swfc_status.sv
module swfc_status #(
   parameter int FLAGS = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [FLAGS-1:0] set,
   input  logic             rd,
   output logic [FLAGS-1:0] flags
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) flags <= '0;
      else        flags <= (rd ? '0 : flags) | set;
   end

endmodule

// File: rtl/swfc_flow_ctrl.sv
module swfc_flow_ctrl
   import swfc_pkg::*;
#(
   parameter int CHAR_W     = 8,
   parameter int LVL_W      = 8,
   parameter int THR_W      = 4,
   parameter int UNIT_SHIFT = 3,
   parameter bit WAIT_FRAME = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [7:3]        ctl_bits,
   input  logic [CHAR_W-1:0] chr_on_a,
   input  logic [CHAR_W-1:0] chr_on_b,
   input  logic [CHAR_W-1:0] chr_off_a,
   input  logic [CHAR_W-1:0] chr_off_b,
   input  logic [THR_W-1:0]  halt_units,
   input  logic [THR_W-1:0]  resume_units,
   input  logic              rx_valid,
   input  logic [CHAR_W-1:0] rx_data,
   output logic              fwd_valid,
   output logic [CHAR_W-1:0] fwd_data,
   input  logic [LVL_W-1:0]  rx_level,
   input  logic              tx_frame_busy,
   output logic              tx_pause,
   output logic              inj_req,
   output logic [CHAR_W-1:0] inj_char,
   input  logic              inj_ack,
   input  logic              stat_rd,
   output logic [7:0]        stat_byte
);

   localparam int THR_SPAN = THR_W + UNIT_SHIFT;

   if (LVL_W < THR_SPAN) begin : g_bad_level_width
      $error("swfc_flow_ctrl: LVL_W too narrow for the scaled thresholds");
   end
   if (CHAR_W < 5 || CHAR_W > 9) begin : g_bad_char_width
      $error("swfc_flow_ctrl: CHAR_W must be 5 to 9");
   end

   logic [NUM_CHARS-1:0][CHAR_W-1:0] chars;
   logic [1:0]                       rx_sel;
   logic [1:0]                       tx_sel;
   logic                             rx_en;
   logic                             tx_en;
   logic                             on_evt;
   logic                             off_evt;
   logic [NUM_CHARS-1:0]             hit_set;
   logic [NUM_CHARS-1:0]             flags;

   assign chars[IDX_ON_A]  = chr_on_a;
   assign chars[IDX_ON_B]  = chr_on_b;
   assign chars[IDX_OFF_A] = chr_off_a;
   assign chars[IDX_OFF_B] = chr_off_b;

   assign rx_sel = ctl_bits[CTL_RXL +: 2];
   assign tx_sel = ctl_bits[CTL_TXL +: 2];
   assign rx_en  = ctl_bits[CTL_EN] & (rx_sel != 2'(FC_NONE));
   assign tx_en  = ctl_bits[CTL_EN] & (tx_sel != 2'(FC_NONE));

   swfc_rx_match #(.CHAR_W(CHAR_W)) i_match (
      .clk       (clk),
      .rst_n     (rst_n),
      .enable    (rx_en),
      .sel       (rx_sel),
      .chars     (chars),
      .rx_valid  (rx_valid),
      .rx_data   (rx_data),
      .fwd_valid (fwd_valid),
      .fwd_data  (fwd_data),
      .on_evt    (on_evt),
      .off_evt   (off_evt),
      .hit_set   (hit_set)
   );

   swfc_pause #(.WAIT_FRAME(WAIT_FRAME)) i_pause (
      .clk        (clk),
      .rst_n      (rst_n),
      .enable     (rx_en),
      .on_evt     (on_evt),
      .off_evt    (off_evt),
      .frame_busy (tx_frame_busy),
      .pause      (tx_pause)
   );

   swfc_tx_inject #(
      .CHAR_W     (CHAR_W),
      .LVL_W      (LVL_W),
      .THR_W      (THR_W),
      .UNIT_SHIFT (UNIT_SHIFT)
   ) i_inject (
      .clk          (clk),
      .rst_n        (rst_n),
      .enable       (tx_en),
      .sel          (tx_sel),
      .chars        (chars),
      .level        (rx_level),
      .halt_units   (halt_units),
      .resume_units (resume_units),
      .ack          (inj_ack),
      .req          (inj_req),
      .chr          (inj_char)
   );

   swfc_status #(.FLAGS(NUM_CHARS)) i_status (
      .clk   (clk),
      .rst_n (rst_n),
      .set   (hit_set),
      .rd    (stat_rd),
      .flags (flags)
   );

   assign stat_byte = {{(8-NUM_CHARS){1'b0}}, flags};

endmodule

// File: rtl/swfc_flow_ctrl_chk.sv
module swfc_flow_ctrl_chk #(
   parameter int CHAR_W     = 8,
   parameter bit WAIT_FRAME = 1'b1
) (
   input logic              clk,
   input logic              rst_n,
   input logic [7:3]        ctl_bits,
   input logic              rx_valid,
   input logic              tx_frame_busy,
   input logic              tx_pause,
   input logic              inj_req,
   input logic [CHAR_W-1:0] inj_char,
   input logic              inj_ack,
   input logic              fwd_valid,
   input logic              stat_rd,
   input logic [7:0]        stat_byte
);

   AST_PAUSE_AFTER_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(tx_pause) && WAIT_FRAME) |-> $past(!tx_frame_busy)); // R5

   AST_PAUSE_OFF_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
      (!ctl_bits[3] || ctl_bits[5:4] == 2'b00) |=> !tx_pause); // R12

   AST_NO_INJECT_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
      (!ctl_bits[3] || ctl_bits[7:6] == 2'b00) |=> !inj_req); // R2

   AST_INJECT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (inj_req && !inj_ack && ctl_bits[3] && ctl_bits[7:6] != 2'b00)
      |=> (inj_req && $stable(inj_char))); // R10

   AST_FWD_FROM_INPUT: assert property (@(posedge clk) disable iff (!rst_n)
      fwd_valid |-> $past(rx_valid)); // R7

   AST_STATUS_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      !stat_rd |=> ((stat_byte & $past(stat_byte)) == $past(stat_byte))); // R11

endmodule

bind swfc_flow_ctrl swfc_flow_ctrl_chk #(
   .CHAR_W     (CHAR_W),
   .WAIT_FRAME (WAIT_FRAME)
) i_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .ctl_bits      (ctl_bits),
   .rx_valid      (rx_valid),
   .tx_frame_busy (tx_frame_busy),
   .tx_pause      (tx_pause),
   .inj_req       (inj_req),
   .inj_char      (inj_char),
   .inj_ack       (inj_ack),
   .fwd_valid     (fwd_valid),
   .stat_rd       (stat_rd),
   .stat_byte     (stat_byte)
);

// File: tb/test_swfc_flow_ctrl.sv
`timescale 1ns/1ps
module test_swfc_flow_ctrl;

   localparam logic [7:0] ON_A  = 8'h11;
   localparam logic [7:0] ON_B  = 8'h12;
   localparam logic [7:0] OFF_A = 8'h13;
   localparam logic [7:0] OFF_B = 8'h14;
   localparam logic [7:0] PLAIN = 8'h41;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [7:3] ctl_bits = '0;
   logic [3:0] halt_units = 4'd2;
   logic [3:0] resume_units = 4'd1;
   logic       rx_valid = 1'b0;
   logic [7:0] rx_data = '0;
   logic       fwd_valid;
   logic [7:0] fwd_data;
   logic [7:0] rx_level = '0;
   logic       tx_frame_busy = 1'b0;
   logic       tx_pause;
   logic       inj_req;
   logic [7:0] inj_char;
   logic       inj_ack = 1'b0;
   logic       stat_rd = 1'b0;
   logic [7:0] stat_byte;

   int n_checks = 0;
   int n_fail   = 0;
   bit done     = 1'b0;

   always #4 clk = ~clk;

   swfc_flow_ctrl i_swfc_flow_ctrl (
      .clk           (clk),
      .rst_n         (rst_n),
      .ctl_bits      (ctl_bits),
      .chr_on_a      (ON_A),
      .chr_on_b      (ON_B),
      .chr_off_a     (OFF_A),
      .chr_off_b     (OFF_B),
      .halt_units    (halt_units),
      .resume_units  (resume_units),
      .rx_valid      (rx_valid),
      .rx_data       (rx_data),
      .fwd_valid     (fwd_valid),
      .fwd_data      (fwd_data),
      .rx_level      (rx_level),
      .tx_frame_busy (tx_frame_busy),
      .tx_pause      (tx_pause),
      .inj_req       (inj_req),
      .inj_char      (inj_char),
      .inj_ack       (inj_ack),
      .stat_rd       (stat_rd),
      .stat_byte     (stat_byte)
   );

   // receive table: {rx mode, character, forwarded, status flags}
   localparam int NVEC = 10;
   localparam logic [14:0] VEC [NVEC] = '{
      {2'b00, ON_A,  1'b1, 4'b0000},
      {2'b00, OFF_A, 1'b1, 4'b0000},
      {2'b01, ON_B,  1'b0, 4'b0010},
      {2'b01, OFF_B, 1'b0, 4'b1000},
      {2'b01, ON_A,  1'b1, 4'b0000},
      {2'b10, ON_A,  1'b0, 4'b0001},
      {2'b10, OFF_A, 1'b0, 4'b0100},
      {2'b10, OFF_B, 1'b1, 4'b0000},
      {2'b11, ON_B,  1'b1, 4'b0000},
      {2'b11, PLAIN, 1'b1, 4'b0000}
   };

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic send_char(input logic [7:0] c);
      @(negedge clk); rx_valid = 1'b1; rx_data = c;
      @(negedge clk); rx_valid = 1'b0;
   endtask

   task automatic read_status();
      @(negedge clk); stat_rd = 1'b1;
      @(negedge clk); stat_rd = 1'b0;
   endtask

   task automatic ack_pulse();
      @(negedge clk); inj_ack = 1'b1;
      @(negedge clk); inj_ack = 1'b0;
   endtask

   function automatic logic [7:3] mk_ctl(input logic [1:0] tx, input logic [1:0] rx, input logic en);
      return {tx, rx, en};
   endfunction

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_checks++; n_fail++;
         $display("FAIL watchdog: actual hung expected finished");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      chk("R1 pause", 32'(tx_pause), 0);
      chk("R1 inj_req", 32'(inj_req), 0);
      chk("R1 fwd_valid", 32'(fwd_valid), 0);
      chk("R1 stat", 32'(stat_byte), 0);

      // table of single characters per receive mode
      for (int k = 0; k < NVEC; k++) begin
         @(negedge clk); ctl_bits = mk_ctl(2'b00, VEC[k][14:13], 1'b1);
         send_char(PLAIN);
         send_char(VEC[k][12:5]);
         chk("R3/R7 forward", 32'(fwd_valid), 32'(VEC[k][4]));
         if (VEC[k][4]) chk("R7 data", 32'(fwd_data), 32'(VEC[k][12:5]));
         chk("R3/R11 flags", 32'(stat_byte), 32'(VEC[k][3:0]));
         read_status();
         chk("R11 clear on read", 32'(stat_byte), 0);
      end

      // R4 paired resume; pause from table entry 6 is released (R6)
      @(negedge clk); ctl_bits = mk_ctl(2'b00, 2'b11, 1'b1);
      chk("R5 pause from earlier stop", 32'(tx_pause), 1);
      send_char(ON_A);
      chk("R4 first of pair forwarded", 32'(fwd_valid), 1);
      send_char(ON_B);
      chk("R4 second of pair withheld", 32'(fwd_valid), 0);
      chk("R11 pair sets both", 32'(stat_byte), 32'h03);
      chk("R6 resume clears pause", 32'(tx_pause), 0);
      read_status();

      // R4/R5 paired stop
      send_char(OFF_A);
      send_char(OFF_B);
      chk("R5 pause not yet", 32'(tx_pause), 0);
      chk("R11 stop pair flags", 32'(stat_byte), 32'h0C);
      @(negedge clk);
      chk("R5 pause set", 32'(tx_pause), 1);
      read_status();

      // R4 broken pair
      send_char(OFF_A);
      send_char(PLAIN);
      send_char(OFF_B);
      chk("R4 broken pair forwarded", 32'(fwd_valid), 1);
      chk("R4 broken pair no flag", 32'(stat_byte), 0);

      // R12 matching off clears pause
      @(negedge clk); ctl_bits = mk_ctl(2'b00, 2'b00, 1'b1);
      @(negedge clk);
      chk("R12 pause cleared", 32'(tx_pause), 0);

      // R2 master enable off
      @(negedge clk); ctl_bits = mk_ctl(2'b10, 2'b10, 1'b0);
      rx_level = 8'd40;
      send_char(OFF_A);
      chk("R2 forwarded", 32'(fwd_valid), 1);
      chk("R2 no flag", 32'(stat_byte), 0);
      @(negedge clk);
      chk("R2 no pause", 32'(tx_pause), 0);
      chk("R2 no inject", 32'(inj_req), 0);
      rx_level = 8'd0;

      // R5 wait for frame end
      @(negedge clk); ctl_bits = mk_ctl(2'b00, 2'b10, 1'b1); tx_frame_busy = 1'b1;
      send_char(OFF_A);
      repeat (3) @(negedge clk);
      chk("R5 held while busy", 32'(tx_pause), 0);
      tx_frame_busy = 1'b0;
      @(negedge clk);
      chk("R5 set after frame", 32'(tx_pause), 1);
      send_char(ON_A);
      read_status();

      // R8/R9/R10 generation, mode 10
      @(negedge clk); ctl_bits = mk_ctl(2'b10, 2'b00, 1'b1); rx_level = 8'd15;
      repeat (2) @(negedge clk);
      chk("R8 below halt", 32'(inj_req), 0);
      rx_level = 8'd16;
      @(negedge clk);
      chk("R8 stop requested", 32'(inj_req), 1);
      chk("R10 stop char set A", 32'(inj_char), 32'(OFF_A));
      repeat (3) @(negedge clk);
      chk("R10 held until ack", 32'(inj_req), 1);
      chk("R10 char stable", 32'(inj_char), 32'(OFF_A));
      ack_pulse();
      chk("R8 done after ack", 32'(inj_req), 0);
      rx_level = 8'd20;
      repeat (4) @(negedge clk);
      chk("R8 sent once", 32'(inj_req), 0);
      rx_level = 8'd9;
      repeat (2) @(negedge clk);
      chk("R9 above resume", 32'(inj_req), 0);
      rx_level = 8'd8;
      @(negedge clk);
      chk("R9 resume requested", 32'(inj_req), 1);
      chk("R10 resume char set A", 32'(inj_char), 32'(ON_A));
      ack_pulse();
      chk("R9 done", 32'(inj_req), 0);

      // R10 mode 11 sequences
      @(negedge clk); ctl_bits = mk_ctl(2'b11, 2'b00, 1'b1); rx_level = 8'd16;
      @(negedge clk);
      chk("R10 pair stop first", 32'(inj_char), 32'(OFF_A));
      ack_pulse();
      chk("R10 pair stop second req", 32'(inj_req), 1);
      chk("R10 pair stop second", 32'(inj_char), 32'(OFF_B));
      ack_pulse();
      chk("R10 pair stop done", 32'(inj_req), 0);
      rx_level = 8'd8;
      @(negedge clk);
      chk("R10 pair resume first", 32'(inj_char), 32'(ON_A));
      ack_pulse();
      chk("R10 pair resume second", 32'(inj_char), 32'(ON_B));
      ack_pulse();
      chk("R10 pair resume done", 32'(inj_req), 0);

      // R10 mode 01
      @(negedge clk); ctl_bits = mk_ctl(2'b01, 2'b00, 1'b1); rx_level = 8'd16;
      @(negedge clk);
      chk("R10 set B stop", 32'(inj_char), 32'(OFF_B));
      ack_pulse();
      rx_level = 8'd8;
      @(negedge clk);
      chk("R10 set B resume", 32'(inj_char), 32'(ON_B));
      ack_pulse();

      // R12 generation off drops request
      @(negedge clk); ctl_bits = mk_ctl(2'b10, 2'b00, 1'b1); rx_level = 8'd16;
      @(negedge clk);
      chk("R12 request up", 32'(inj_req), 1);
      ctl_bits = mk_ctl(2'b00, 2'b00, 1'b1);
      @(negedge clk);
      chk("R12 request dropped", 32'(inj_req), 0);

      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
      $finish;
   end

endmodule